// File: doc/BRIEF.md
# Streaming Web and Ping Packet Classifier

This block sits in the middle of a byte-wide Ethernet frame stream, between a receiver and a transmitter. Each frame passes through a fixed look-ahead delay line. While the frame's first byte travels down that line, the block reads the type, IPv4 and transport fields. By the time the first byte reaches the end of the line, the frame is sorted into one of three classes: web, ping or other. Web frames bump a web counter and leave on the transmit stream. Echo requests leave on a side stream for slow-path software. All remaining frames go to transmit unchanged.

The slow path returns its frames on a return stream. These are merged back onto transmit one whole frame at a time. A returned frame never cuts into an inline frame that is already on the wire. At a frame boundary, a returned frame wins. While it owns transmit, the inline pipeline is frozen through `in_ready`. Two counters, saturating at all ones, are read through a one-bit select.

The upstream source must keep a frame's bytes on consecutive accepted cycles. It may pause only where the block itself drops `in_ready`. The side stream has no back-pressure.

Top module: `web_ping_classifier`

## Requirements
- R1: A frame is IPv4 only if bytes 12 and 13 (first byte most significant) equal 0x0800, the upper nibble of byte 14 equals 4, and the lower nibble of byte 14 (header length in 32-bit words) is 5 or more. Any other frame is class other.
- R2: The transport header starts at byte offset T = 14 + 4 × (lower nibble of byte 14), so IP options move it. This holds for every header length from 5 to 15.
- R3: An IPv4 frame whose byte 23 equals 6 is web when the 16-bit value at T..T+1 or the one at T+2..T+3 equals 80. The frame must reach byte T+3. A web frame leaves on tx and raises the web counter by one.
- R4: An IPv4 frame whose byte 23 equals 1 is ping when byte T equals 8 and byte T+1 equals 0. The frame must reach byte T+1. It leaves only on the side port, never inline on tx. The ping counter rises by one when the frame's last byte is presented on the side port.
- R5: Every other frame leaves on tx with no counter change. This includes echo replies (type 0), UDP on port 80, non-IPv4 frames, bad version or length nibbles, and frames cut short before the needed bytes.
- R6: Frames on tx and on the side port carry exactly the input bytes and length. Inline frames on tx keep their input order.
- R7: Frames taken on the return port appear on tx whole and in order, never interleaved with an inline frame. Once a returned frame starts, the return port stays ready until its last byte.
- R8: Both counters saturate at all ones and never step by more than one per cycle.
- R9: `rd_data` shows the web counter when `rd_sel` is 0 and the ping counter when it is 1.
- R10: Right after reset, `tx_valid` and `side_valid` are low, `in_ready` is high and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Last byte of input frame |
| in_ready | output | 1 | Input byte accepted this cycle when high |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Last byte of transmit frame |
| side_valid | output | 1 | Side (slow path) byte valid |
| side_data | output | 8 | Side byte |
| side_last | output | 1 | Last byte of side frame |
| ret_valid | input | 1 | Returned byte valid |
| ret_data | input | 8 | Returned frame byte |
| ret_last | input | 1 | Last byte of returned frame |
| ret_ready | output | 1 | Returned byte accepted this cycle when high |
| rd_sel | input | 1 | Counter select: 0 web, 1 ping |
| rd_data | output | CW | Selected counter value |

## Verification
Random frames mix several kinds. Web frames match on either the source or the destination port, which separates the two port compares. They are set against TCP frames on other ports and UDP frames on port 80, which separate the protocol test from the port test. Echo requests are set against echo replies, which isolates the type compare. Non-IPv4 types, version 6 and header lengths below 5 probe the IPv4 gate. Random header lengths from 5 to 15 show whether the transport offset is taken from the length nibble rather than a fixed place. Frames cut just short of the port or code bytes, a tiny frame and a maximal-offset frame check the decision at the frame end. The bench loops side frames back with random gaps, which exercises frozen inline traffic and boundary arbitration. A small counter width drives both counters into saturation.

// File: rtl/web_ping_classifier.sv
module web_ping_classifier #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          side_valid,
  output logic [7:0]    side_data,
  output logic          side_last,
  input  logic          ret_valid,
  input  logic [7:0]    ret_data,
  input  logic          ret_last,
  output logic          ret_ready,
  input  logic          rd_sel,
  output logic [CW-1:0] rd_data
);
  localparam int MAXHDR = 60;
  localparam int LOOK   = 14 + MAXHDR + 4;
  localparam int DEPTH  = LOOK + 2;
  localparam int IW     = 7;
  localparam int H      = DEPTH - 1;
  localparam logic [1:0] C_OTH = 2'd0, C_WEB = 2'd1, C_PING = 2'd2;

  logic [DEPTH-1:0] sv, ss, sl;
  logic [7:0]       sd [DEPTH];
  logic [1:0]       sc [DEPTH];

  logic [IW-1:0] idx, ppos, toff, tgt;
  logic [15:0]   etype;
  logic [7:0]    verihl, proto, p0, p1, p2, p3;
  logic          seen1, seen3, dec_done, pend;
  logic [1:0]    dcls, cur_cls, hcls;
  logic          ret_own, inl_busy, own, shift, accept, trig, to_side, to_inl;
  logic          is_v4, is_web, is_ping;
  logic [CW-1:0] web_cnt, ping_cnt;

  assign toff    = IW'(14) + IW'({verihl[3:0], 2'b00});
  assign is_v4   = etype == 16'h0800 && verihl[7:4] == 4'd4 && verihl[3:0] >= 4'd5;
  assign is_web  = is_v4 && proto == 8'd6 && seen3 && ({p0, p1} == 16'd80 || {p2, p3} == 16'd80);
  assign is_ping = is_v4 && proto == 8'd1 && seen1 && p0 == 8'd8 && p1 == 8'd0;
  assign dcls    = is_web ? C_WEB : (is_ping ? C_PING : C_OTH);

  assign hcls    = ss[H] ? sc[H] : cur_cls;
  assign to_side = sv[H] && hcls == C_PING;
  assign to_inl  = sv[H] && hcls != C_PING;
  assign own     = ret_own || (ret_valid && !inl_busy);
  assign shift   = !(to_inl && own);
  assign accept  = in_valid && shift;
  assign trig    = accept && !dec_done && (in_last || idx == IW'(LOOK - 1));
  assign tgt     = ppos + IW'(shift);

  assign in_ready   = shift;
  assign ret_ready  = own;
  assign tx_valid   = own ? ret_valid : to_inl;
  assign tx_data    = own ? ret_data  : sd[H];
  assign tx_last    = own ? ret_last  : sl[H];
  assign side_valid = to_side;
  assign side_data  = sd[H];
  assign side_last  = sl[H];
  assign rd_data    = rd_sel ? ping_cnt : web_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; etype <= '0; verihl <= '0; proto <= '0;
      p0 <= '0; p1 <= '0; p2 <= '0; p3 <= '0;
      seen1 <= 1'b0; seen3 <= 1'b0; dec_done <= 1'b0;
      pend <= 1'b0; ppos <= '0;
    end else begin
      pend <= trig;
      if (accept) begin
        if (idx == '0) begin
          etype <= '0; verihl <= '0; proto <= '0;
          seen1 <= 1'b0; seen3 <= 1'b0; dec_done <= 1'b0;
        end
        if (idx == IW'(12)) etype[15:8] <= in_data;
        if (idx == IW'(13)) etype[7:0]  <= in_data;
        if (idx == IW'(14)) verihl      <= in_data;
        if (idx == IW'(23)) proto       <= in_data;
        if (idx == toff)          p0 <= in_data;
        if (idx == toff + IW'(1)) begin p1 <= in_data; seen1 <= 1'b1; end
        if (idx == toff + IW'(2)) p2 <= in_data;
        if (idx == toff + IW'(3)) begin p3 <= in_data; seen3 <= 1'b1; end
        if (trig) begin dec_done <= 1'b1; ppos <= idx; end
        idx <= in_last ? '0 : ((&idx) ? idx : idx + IW'(1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sv <= '0; ss <= '0; sl <= '0;
      cur_cls <= C_OTH; ret_own <= 1'b0; inl_busy <= 1'b0;
      web_cnt <= '0; ping_cnt <= '0;
    end else begin
      if (shift) begin
        sv <= {sv[DEPTH-2:0], accept};
        ss <= {ss[DEPTH-2:0], accept && idx == '0};
        sl <= {sl[DEPTH-2:0], in_last};
        if (sv[H] && ss[H]) cur_cls <= sc[H];
      end
      ret_own <= own && !(ret_valid && ret_last);
      if (to_inl && !own) inl_busy <= !sl[H];
      if (pend && dcls == C_WEB && !(&web_cnt)) web_cnt <= web_cnt + 1'b1;
      if (to_side && sl[H] && !(&ping_cnt)) ping_cnt <= ping_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (shift) begin
      sd[0] <= in_data;
      sc[0] <= C_OTH;
      for (int i = 1; i < DEPTH; i++) begin
        sd[i] <= sd[i-1];
        sc[i] <= sc[i-1];
      end
    end
    if (pend) sc[tgt] <= dcls;
  end
endmodule

module web_ping_classifier_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          side_valid,
  input logic          ret_valid,
  input logic [7:0]    ret_data,
  input logic          ret_last,
  input logic          ret_ready,
  input logic [CW-1:0] web_cnt,
  input logic [CW-1:0] ping_cnt
);
  assert_ret_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_ready) |-> (tx_valid && tx_data == ret_data));
  assert_ret_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_ready && !ret_last) |=> ret_ready);
  assert_side_flow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    side_valid |-> in_ready);
  assert_web_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (web_cnt != $past(web_cnt)) |-> (web_cnt == $past(web_cnt) + 1'b1));
  assert_ping_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ping_cnt != $past(ping_cnt)) |-> (ping_cnt == $past(ping_cnt) + 1'b1));
  assert_web_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&web_cnt) |=> (&web_cnt));
  assert_ping_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&ping_cnt) |=> (&ping_cnt));
endmodule

bind web_ping_classifier web_ping_classifier_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .side_valid(side_valid), .ret_valid(ret_valid),
  .ret_data(ret_data), .ret_last(ret_last), .ret_ready(ret_ready),
  .web_cnt(web_cnt), .ping_cnt(ping_cnt)
);

// File: tb/web_ping_classifier_bench.sv
`timescale 1ns/1ps
module web_ping_classifier_bench;
  localparam int CW = 3;
  localparam int NRAND = 70;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, ret_valid = 1'b0, ret_last = 1'b0, rd_sel = 1'b0;
  logic [7:0] in_data = '0, ret_data = '0;
  logic in_ready, tx_valid, tx_last, side_valid, side_last, ret_ready;
  logic [7:0] tx_data, side_data;
  logic [CW-1:0] rd_data;

  always #2.5 clk = ~clk;

  web_ping_classifier #(.CW(CW)) u_web_ping_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .side_valid(side_valid), .side_data(side_data), .side_last(side_last),
    .ret_valid(ret_valid), .ret_data(ret_data), .ret_last(ret_last), .ret_ready(ret_ready),
    .rd_sel(rd_sel), .rd_data(rd_data));

  int checks = 0, fails = 0, finished = 0;
  int exp_web = 0, exp_ping = 0;
  logic [7:0] fr [256];
  int flen;
  logic [47:0] exp_inl[$], exp_side[$], exp_ret[$];
  logic [7:0] ret_bytes[$];
  int ret_lens[$];

  function automatic logic [31:0] hstep(logic [31:0] h, logic [7:0] b);
    return h * 32'd31 + {24'd0, b};
  endfunction

  function automatic logic [1:0] classify(int n);
    int t;
    if (n <= 23) return 2'd0;
    if (fr[12] != 8'h08 || fr[13] != 8'h00) return 2'd0;
    if (fr[14][7:4] != 4'd4 || fr[14][3:0] < 4'd5) return 2'd0;
    t = 14 + 4 * int'(fr[14][3:0]);
    if (fr[23] == 8'd6 && n >= t + 4 &&
        (({fr[t], fr[t+1]} == 16'd80) || ({fr[t+2], fr[t+3]} == 16'd80))) return 2'd1;
    if (fr[23] == 8'd1 && n >= t + 2 && fr[t] == 8'd8 && fr[t+1] == 8'd0) return 2'd2;
    return 2'd0;
  endfunction

  function automatic int sat(int v);
    int m = (1 << CW) - 1;
    return v > m ? m : v;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic build(int kind, int ihl, int extra);
    int t = 14 + 4 * ihl;
    for (int i = 0; i < 256; i++) fr[i] = 8'($urandom);
    fr[12] = 8'h08; fr[13] = 8'h00; fr[14] = {4'h4, 4'(ihl)};
    fr[t] = 8'hC0 | fr[t]; fr[t+2] = 8'hC0 | fr[t+2];
    flen = t + 4 + extra;
    case (kind)
      0: begin fr[23] = 8'd6; fr[t+2] = 8'd0; fr[t+3] = 8'd80; end
      1: begin fr[23] = 8'd6; fr[t] = 8'd0; fr[t+1] = 8'd80; end
      2: fr[23] = 8'd6;
      3: begin fr[23] = 8'd1; fr[t] = 8'd8; fr[t+1] = 8'd0; flen = t + 2 + extra; end
      4: begin fr[23] = 8'd1; fr[t] = 8'd0; fr[t+1] = 8'd0; end
      5: begin fr[23] = 8'd17; fr[t+2] = 8'd0; fr[t+3] = 8'd80; end
      6: begin fr[23] = 8'd6; fr[12] = 8'h86; fr[13] = 8'hDD; fr[t+2] = 8'd0; fr[t+3] = 8'd80; end
      7: begin fr[23] = 8'd6; fr[14] = {4'h6, 4'(ihl)}; fr[t+2] = 8'd0; fr[t+3] = 8'd80; end
      8: begin fr[23] = 8'd6; fr[14] = {4'h4, 4'($urandom_range(0, 4))}; end
      default: begin fr[23] = 8'd6; fr[t+2] = 8'd0; fr[t+3] = 8'd80; flen = t + 3; end
    endcase
  endtask

  task automatic send();
    logic [1:0] c = classify(flen);
    logic [31:0] h = 32'd0;
    for (int i = 0; i < flen; i++) h = hstep(h, fr[i]);
    if (c == 2'd2) begin exp_side.push_back({16'(flen), h}); exp_ping++; end
    else begin exp_inl.push_back({16'(flen), h}); if (c == 2'd1) exp_web++; end
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fr[i]; in_last = (i == flen - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat ($urandom_range(0, 4)) @(negedge clk);
  endtask

  initial begin : tx_mon
    logic [31:0] th = 0, sh = 0;
    int tl = 0, sl = 0;
    logic [7:0] sbuf[$];
    forever begin
      @(negedge clk); #2;
      if (rst_n && tx_valid) begin
        th = hstep(th, tx_data); tl++;
        if (tx_last) begin
          if (exp_inl.size() > 0 && exp_inl[0] == {16'(tl), th}) begin
            void'(exp_inl.pop_front()); check(1'b1, "R6", "inline frame", 0, 0);
          end else if (exp_ret.size() > 0 && exp_ret[0] == {16'(tl), th}) begin
            void'(exp_ret.pop_front()); check(1'b1, "R7", "returned frame", 0, 0);
          end else
            check(1'b0, "R5", "tx frame len/hash", {16'(tl), th},
                  exp_inl.size() > 0 ? exp_inl[0] : 48'd0);
          th = 0; tl = 0;
        end
      end
      if (rst_n && side_valid) begin
        sh = hstep(sh, side_data); sl++; sbuf.push_back(side_data);
        if (side_last) begin
          check(exp_side.size() > 0 && exp_side[0] == {16'(sl), sh}, "R4", "side frame",
                {16'(sl), sh}, exp_side.size() > 0 ? exp_side[0] : 48'd0);
          if (exp_side.size() > 0) void'(exp_side.pop_front());
          exp_ret.push_back({16'(sl), sh});
          while (sbuf.size() > 0) ret_bytes.push_back(sbuf.pop_front());
          ret_lens.push_back(sl);
          sh = 0; sl = 0;
        end
      end
    end
  end

  initial begin : ret_drv
    int rem = 0;
    bit take = 0;
    forever begin
      @(negedge clk);
      if (take) begin void'(ret_bytes.pop_front()); rem--; end
      if (rem == 0 && ret_lens.size() > 0 && $urandom_range(0, 3) == 0) rem = ret_lens.pop_front();
      ret_valid = rem > 0 && $urandom_range(0, 3) != 0;
      ret_data  = ret_bytes.size() > 0 ? ret_bytes[0] : 8'd0;
      ret_last  = rem == 1;
      #1;
      take = ret_valid && ret_ready;
    end
  end

  task automatic summary();
    if (finished == 0) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual running expected done");
    summary();
  end

  initial begin : main
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    #1;
    check(tx_valid == 1'b0, "R10", "tx_valid in reset", tx_valid, 0);
    check(side_valid == 1'b0, "R10", "side_valid in reset", side_valid, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    check(rd_data == '0, "R10", "web count after reset", rd_data, 0);
    rd_sel = 1'b1; #1;
    check(rd_data == '0, "R10", "ping count after reset", rd_data, 0);
    rd_sel = 1'b0;
    build(0, 15, 0); send();           // R2 deepest transport offset, web
    build(3, 5, 0);  send();           // R4 shortest ping frame
    build(3, 9, 6);  send();           // R2 ping behind options
    build(1, 5, 3);  send();           // R3 source port match
    build(4, 5, 2);  send();           // R5 echo reply
    build(9, 7, 0);  send();           // R5 truncated web
    build(8, 5, 2);  send();           // R1 short header length
    for (int i = 0; i < 5; i++) fr[i] = 8'(i);
    flen = 5; send();                  // R5 tiny frame
    for (int k = 0; k < NRAND; k++) begin
      build($urandom_range(0, 9), $urandom_range(5, 15), $urandom_range(0, 30));
      send();
    end
    for (int w = 0; w < 20000; w++) begin
      @(negedge clk);
      if (exp_inl.size() == 0 && exp_side.size() == 0 && exp_ret.size() == 0 &&
          ret_lens.size() == 0 && ret_bytes.size() == 0) break;
    end
    repeat (5) @(negedge clk);
    check(exp_inl.size() == 0, "R6", "inline frames left", exp_inl.size(), 0);
    check(exp_side.size() == 0, "R4", "side frames left", exp_side.size(), 0);
    check(exp_ret.size() == 0, "R7", "returned frames left", exp_ret.size(), 0);
    rd_sel = 1'b0; #1;
    check(int'(rd_data) == sat(exp_web), "R3 R8 R9", "web count", rd_data, sat(exp_web));
    rd_sel = 1'b1; #1;
    check(int'(rd_data) == sat(exp_ping), "R4 R8 R9", "ping count", rd_data, sat(exp_ping));
    summary();
  end
endmodule